// File: doc/BRIEF.md
# Dual-Bus Register File with Tri-State Ports

This block is a bank of general-purpose registers placed between two shared, bidirectional data buses, called A and B. Each bus has three controls of its own: a register number, a load strobe and an active-low drive strobe. A rising load strobe stores the word on that bus into the register whose number is selected. While the drive strobe is held low, the selected register is placed on the bus. When the drive strobe is high, the block releases the bus so that other devices on the datapath can use it.

The two buses are fully independent and can be used at the same time. For example, one bus can load while the other reads, or both buses can read two different registers. The load strobes are not clocks. Each one is synchronised to the free-running system clock, and its rising transition is detected inside the block. The datapath controller is expected to keep every bus word stable for several clock cycles around a load strobe. It is also expected never to load and drive the same register at the same time.

Top module: `dbus_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero; after reset, every register number read on either bus returns 0.
- R2: While reset is high, neither bus is driven by the block, even when its drive strobe is low.
- R3: While a bus's drive strobe is low, that bus carries the register selected by that bus's register number, and the value follows a change of the register number without the strobe being released.
- R4: While a bus's drive strobe is high, the block leaves that bus undriven, so a value placed on it by another device reads back unchanged.
- R5: A rising edge on a bus's load strobe stores the word on that bus into the selected register. The new value is visible by the fourth rising clock edge after the strobe rises.
- R6: One rising load edge makes exactly one write. If the bus word changes while the strobe stays high, the register keeps the word that was present when the edge was detected.
- R7: Both buses operate in the same cycles in any combination: load on A while reading on B, load on B while reading on A, loads on both buses to different registers, and reads on both buses.
- R8: If both buses load the same register on the same detected edge, the word from bus B is kept.
- R9: Each of the 16 registers (numbers 0 to 15, 16 bits wide) holds its own value. A write to one register number leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 4 | Register number for bus A |
| a_load | input | 1 | Load strobe for bus A; its rising edge writes |
| a_drive_n | input | 1 | Active-low drive strobe for bus A |
| a_bus | inout | 16 | Bidirectional data bus A |
| b_sel | input | 4 | Register number for bus B |
| b_load | input | 1 | Load strobe for bus B; its rising edge writes |
| b_drive_n | input | 1 | Active-low drive strobe for bus B |
| b_bus | inout | 16 | Bidirectional data bus B |

## Verification
The main overlap is a load on one bus happening while the other bus is being driven. A second overlap is two load edges arriving on the same clock edge. The bench produces both by raising the two load strobes in the same cycle, or by combining one load with a drive on the other bus, on randomly chosen register pairs. The driven bus is sampled in the middle of the load window and must still show the model's old contents of its own register. For the same-register pair, a later read-back must return bus B's word.

// File: rtl/dbrf_pkg.sv
`timescale 1ns/1ps
package dbrf_pkg;
  localparam int unsigned DEF_NUM_REGS    = 16;
  localparam int unsigned DEF_DATA_W      = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // rising transition of a synchronised level against its previous sample
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // a port may put data on its bus only outside reset and with its strobe low
  function automatic logic may_drive(input logic in_reset, input logic drive_n);
    return ~in_reset & ~drive_n;
  endfunction
endpackage

// File: rtl/dbrf_strobe_sync.sv
`timescale 1ns/1ps
module dbrf_strobe_sync #(
  parameter int unsigned STAGES = dbrf_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  localparam int unsigned NST = (STAGES < 1) ? 1 : STAGES;

  logic [NST-1:0] chain;
  logic           prev;

  generate
    if (NST == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= strobe;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[NST-2:0], strobe};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[NST-1];
  end

  assign rise = dbrf_pkg::rise_of(chain[NST-1], prev);
endmodule

// File: rtl/dbrf_port.sv
`timescale 1ns/1ps
module dbrf_port #(
  parameter int unsigned DATA_W      = dbrf_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = dbrf_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              drive_n,
  input  logic [DATA_W-1:0] rd_data,
  inout  wire  [DATA_W-1:0] bus,
  output logic              wr_fire,
  output logic [DATA_W-1:0] wr_data,
  output logic              oe
);
  dbrf_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .strobe (load),
    .rise   (wr_fire)
  );

  assign oe      = dbrf_pkg::may_drive(rst, drive_n);
  assign bus     = oe ? rd_data : 'z;
  assign wr_data = bus;
endmodule

// File: rtl/dbrf_core.sv
`timescale 1ns/1ps
module dbrf_core #(
  parameter int unsigned NUM_REGS = dbrf_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = dbrf_pkg::DEF_DATA_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [SEL_W-1:0]  a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_we,
  input  logic [SEL_W-1:0]  b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      logic hit_a, hit_b;
      assign hit_a = a_we && (a_addr == SEL_W'(gi));
      assign hit_b = b_we && (b_addr == SEL_W'(gi));
      always_ff @(posedge clk) begin
        if (rst)        regs[gi] <= '0;
        else if (hit_b) regs[gi] <= b_wdata;   // bus B takes precedence
        else if (hit_a) regs[gi] <= a_wdata;
      end
    end
  endgenerate

  assign a_rdata = regs[a_addr];
  assign b_rdata = regs[b_addr];
endmodule

// File: rtl/dbus_regfile.sv
`timescale 1ns/1ps
module dbus_regfile #(
  parameter int unsigned NUM_REGS    = dbrf_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W      = dbrf_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = dbrf_pkg::DEF_SYNC_STAGES,
  localparam int unsigned SEL_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  a_sel,
  input  logic              a_load,
  input  logic              a_drive_n,
  inout  wire  [DATA_W-1:0] a_bus,
  input  logic [SEL_W-1:0]  b_sel,
  input  logic              b_load,
  input  logic              b_drive_n,
  inout  wire  [DATA_W-1:0] b_bus
);
  // named internal events, observed by the bound checker
  logic              a_wr_fire, b_wr_fire;
  logic [DATA_W-1:0] a_wr_data, b_wr_data;
  logic [DATA_W-1:0] a_rd_data, b_rd_data;
  logic              a_oe, b_oe;

  dbrf_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
    .clk(clk), .rst(rst), .load(a_load), .drive_n(a_drive_n),
    .rd_data(a_rd_data), .bus(a_bus),
    .wr_fire(a_wr_fire), .wr_data(a_wr_data), .oe(a_oe)
  );

  dbrf_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
    .clk(clk), .rst(rst), .load(b_load), .drive_n(b_drive_n),
    .rd_data(b_rd_data), .bus(b_bus),
    .wr_fire(b_wr_fire), .wr_data(b_wr_data), .oe(b_oe)
  );

  dbrf_core #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst),
    .a_we(a_wr_fire), .a_addr(a_sel), .a_wdata(a_wr_data),
    .b_we(b_wr_fire), .b_addr(b_sel), .b_wdata(b_wr_data),
    .a_rdata(a_rd_data), .b_rdata(b_rd_data)
  );
endmodule

// File: rtl/dbrf_checker.sv
`timescale 1ns/1ps
module dbrf_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  a_sel,
  input logic [SEL_W-1:0]  b_sel,
  input logic              a_drive_n,
  input logic              b_drive_n,
  input logic              a_wr_fire,
  input logic              b_wr_fire,
  input logic [DATA_W-1:0] a_wr_data,
  input logic [DATA_W-1:0] b_wr_data,
  input logic [DATA_W-1:0] a_rd_data,
  input logic [DATA_W-1:0] b_rd_data,
  input logic              a_oe,
  input logic              b_oe
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_rd_data == '0 && b_rd_data == '0));

  assert_reset_release_R2: assert property (@(posedge clk)
    rst |-> (!a_oe && !b_oe));

  assert_drive_a_R3: assert property (@(posedge clk) disable iff (rst)
    !a_drive_n |-> a_oe);
  assert_drive_b_R3: assert property (@(posedge clk) disable iff (rst)
    !b_drive_n |-> b_oe);

  assert_release_a_R4: assert property (@(posedge clk) disable iff (rst)
    a_drive_n |-> !a_oe);
  assert_release_b_R4: assert property (@(posedge clk) disable iff (rst)
    b_drive_n |-> !b_oe);

  assert_store_a_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(a_wr_fire) && !($past(b_wr_fire) && $past(b_sel) == $past(a_sel))
     && a_sel == $past(a_sel)) |-> a_rd_data == $past(a_wr_data));
  assert_store_b_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(b_wr_fire) && b_sel == $past(b_sel)) |-> b_rd_data == $past(b_wr_data));

  assert_single_fire_a_R6: assert property (@(posedge clk) disable iff (rst)
    a_wr_fire |=> !a_wr_fire);
  assert_single_fire_b_R6: assert property (@(posedge clk) disable iff (rst)
    b_wr_fire |=> !b_wr_fire);

  assert_b_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(a_wr_fire && b_wr_fire && a_sel == b_sel) && a_sel == $past(a_sel))
    |-> a_rd_data == $past(b_wr_data));
endmodule

bind dbus_regfile dbrf_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel),
  .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
  .a_wr_fire(a_wr_fire), .b_wr_fire(b_wr_fire),
  .a_wr_data(a_wr_data), .b_wr_data(b_wr_data),
  .a_rd_data(a_rd_data), .b_rd_data(b_rd_data),
  .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/dbus_regfile_tb.sv
`timescale 1ns/1ps
module dbus_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  a_sel = '0, b_sel = '0;
  logic        a_load = 1'b0, b_load = 1'b0;
  logic        a_drive_n = 1'b1, b_drive_n = 1'b1;
  logic        a_tb_en = 1'b0, b_tb_en = 1'b0;
  logic [15:0] a_tb_val = '0, b_tb_val = '0;
  wire  [15:0] a_bus, b_bus;

  assign a_bus = a_tb_en ? a_tb_val : 'z;
  assign b_bus = b_tb_en ? b_tb_val : 'z;

  always #2.5 clk = ~clk;   // 200 MHz

  dbus_regfile u_dut (
    .clk(clk), .rst(rst),
    .a_sel(a_sel), .a_load(a_load), .a_drive_n(a_drive_n), .a_bus(a_bus),
    .b_sel(b_sel), .b_load(b_load), .b_drive_n(b_drive_n), .b_bus(b_bus)
  );

  int unsigned vectors = 0;
  int unsigned misses  = 0;
  bit          done    = 1'b0;
  logic [15:0] model [16];

  function automatic logic [15:0] expect_after(input logic [15:0] old_v,
      input bit la, input bit lb, input logic [15:0] va, input logic [15:0] vb,
      input bit hit_a, input bit hit_b);
    if (lb && hit_b) return vb;
    if (la && hit_a) return va;
    return old_v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus transaction window; loads and drives may be mixed across buses
  task automatic op(input bit la, input bit lb, input bit da, input bit db,
                    input int ra, input int rb, input logic [15:0] va,
                    input logic [15:0] vb, input string req);
    @(negedge clk);
    a_sel = 4'(ra); b_sel = 4'(rb);
    if (la) begin a_tb_en = 1'b1; a_tb_val = va; end
    if (lb) begin b_tb_en = 1'b1; b_tb_val = vb; end
    a_drive_n = !da; b_drive_n = !db;
    @(negedge clk);
    a_load = la; b_load = lb;
    repeat (2) @(negedge clk);
    if (da) check(req, a_bus, model[ra]);
    if (db) check(req, b_bus, model[rb]);
    repeat (2) @(negedge clk);
    if (da) check(req, a_bus, model[ra]);
    if (db) check(req, b_bus, model[rb]);
    a_load = 1'b0; b_load = 1'b0;
    @(negedge clk);
    a_tb_en = 1'b0; b_tb_en = 1'b0;
    a_drive_n = 1'b1; b_drive_n = 1'b1;
    for (int k = 0; k < 16; k++)
      model[k] = expect_after(model[k], la, lb, va, vb, k == ra, k == rb);
  endtask

  initial begin
    #1_000_000;   // 200,000 cycles
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = '0;
    void'($urandom(32'h1d5e_7a01));

    // R2: during reset the block must not drive; the bench's value reads back
    repeat (2) @(negedge clk);
    a_drive_n = 1'b0; b_drive_n = 1'b0;
    a_tb_en = 1'b1; a_tb_val = 16'hA55A;
    b_tb_en = 1'b1; b_tb_val = 16'h3CC3;
    @(negedge clk);
    check("R2", a_bus, 16'hA55A);
    check("R2", b_bus, 16'h3CC3);
    a_tb_en = 1'b0; b_tb_en = 1'b0;
    a_drive_n = 1'b1; b_drive_n = 1'b1;
    @(negedge clk); rst = 1'b0;

    // R1: every register reads zero after reset, on both buses
    for (int r = 0; r < 16; r++) op(0, 0, 1, 1, r, 15 - r, '0, '0, "R1");

    // R5/R9: fill every register from alternating buses, then read all back
    for (int r = 0; r < 16; r++) begin
      if (r % 2 == 0) op(1, 0, 0, 0, r, 0, 16'(16'h1000 + r * 16'h0111), '0, "R5");
      else            op(0, 1, 0, 0, 0, r, '0, 16'(16'hF000 - r * 16'h0101), "R5");
    end
    for (int r = 0; r < 16; r++) op(0, 0, 1, 1, r, r, '0, '0, "R9");

    // R3: drive strobe held low, register number changed under it
    @(negedge clk);
    a_drive_n = 1'b0;
    for (int r = 0; r < 16; r += 5) begin
      a_sel = 4'(r);
      @(negedge clk);
      check("R3", a_bus, model[r]);
    end
    a_drive_n = 1'b1;

    // R4: strobe high, another device owns the bus
    @(negedge clk);
    b_sel = 4'd3; b_tb_en = 1'b1; b_tb_val = 16'h6B6B;
    @(negedge clk);
    check("R4", b_bus, 16'h6B6B);
    b_tb_en = 1'b0;

    // R6: bus word changes while the load strobe stays high
    @(negedge clk);
    a_sel = 4'd7; a_tb_en = 1'b1; a_tb_val = 16'h1111;
    @(negedge clk); a_load = 1'b1;
    repeat (4) @(negedge clk); a_tb_val = 16'h2222;
    repeat (4) @(negedge clk); a_load = 1'b0;
    @(negedge clk); a_tb_en = 1'b0;
    model[7] = 16'h1111;
    op(0, 0, 1, 0, 7, 0, '0, '0, "R6");

    // R8: both buses load the same register on the same edge
    op(1, 1, 0, 0, 9, 9, 16'hAAAA, 16'hBBBB, "R8");
    op(0, 0, 1, 1, 9, 9, '0, '0, "R8");
    check("R8", model[9], 16'hBBBB);

    // R7: random mixes of concurrent load and drive across buses
    for (int i = 0; i < 300; i++) begin
      int ra, rb, mode;
      logic [15:0] va, vb;
      ra = int'($urandom_range(15));
      rb = int'($urandom_range(15));
      if (rb == ra) rb = (ra + 1 + int'($urandom_range(14))) % 16;
      va = 16'($urandom); vb = 16'($urandom);
      mode = int'($urandom_range(3));
      case (mode)
        0: op(1, 1, 0, 0, ra, rb, va, vb, "R7");
        1: op(1, 0, 0, 1, ra, rb, va, vb, "R7");
        2: op(0, 1, 1, 0, ra, rb, va, vb, "R7");
        default: op(0, 0, 1, 1, ra, rb, va, vb, "R7");
      endcase
    end
    for (int r = 0; r < 16; r++) op(0, 0, 1, 1, r, r, '0, '0, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule